// File: doc/BRIEF.md
# Memory Wait-Count Issue Gate

This block tracks, for a single wavefront, how many memory operations are still in flight and decides whether that wavefront may issue its next instruction. Six counters follow six kinds of traffic: global reads, global writes, local reads, local writes, scalar reads and scalar writes. Each kind has an issue pulse and a completion pulse. The counters are grouped into three wait classes. The vector-memory class covers global reads and global writes. The write class covers global writes. The shared class covers local and scalar traffic, and message operations are reported on the scalar lanes.

A wait instruction loads one threshold per class and puts the wavefront into a waiting status. While it waits, the wavefront is ready only when its oldest buffered instruction is that wait instruction and every class count is at or below its threshold. On the cycle after all three conditions hold, the wavefront goes back to running by itself. A threshold of all ones means that class is not waited on, and a clear command sets all three thresholds to that value. The block also keeps the wavefront's life-cycle status: launch, stall, retire and drain.

Top module: `memwait_gate`

## Requirements
- R1: After a synchronous active-low reset, `status_o` is 0 (stopped), `ready_o` and `err_o` are 0, every counter is 0 and every threshold is all ones.
- R2: Status codes are stopped=0, returning=1, running=2, stalled=3, waiting=4, and no other value appears. A `launch_i` pulse while stopped gives running on the next cycle. While stopped without launch, the status stays stopped. While running, `ready_o` is 1.
- R3: The issue and completion bits are indexed 0 global read, 1 global write, 2 local read, 3 local write, 4 scalar read, 5 scalar write. Each 6-bit counter adds one on an issue and subtracts one on a completion. Both in the same cycle leave it unchanged.
- R4: The vector-memory class count is kinds 0 and 1 added together. The write class count is kind 1. The shared class count is kinds 2 to 5 added together. Traffic of one kind has no effect on a class that does not include it.
- R5: `wait_load_i` without `wait_clear_i`, while running or waiting, stores the three thresholds. From running, the status becomes waiting on the next cycle, unless `retire_i` is also high.
- R6: While waiting, `ready_o` is 1 only when `oldest_is_wait_i` is 1 and every class count is at or below its threshold.
- R7: While waiting, once every class condition is met and no new threshold load arrives, the status becomes running on the next cycle.
- R8: A threshold of 63 means that class never blocks. `wait_clear_i` sets all three thresholds to 63 and wins over a simultaneous `wait_load_i`.
- R9: A completion on a kind whose counter is 0, or an issue on a kind whose counter is 63 without a paired completion, leaves that counter unchanged and raises `err_o` for one cycle on the next cycle.
- R10: `retire_i` while running gives returning (1) on the next cycle. Returning gives stopped once all six counters are 0. `ready_o` is 0 while returning.
- R11: While running, `hold_i` gives stalled (3) on the next cycle, and stalled returns to running on the cycle after `hold_i` falls. In the running status, retire takes priority over a threshold load, and a threshold load takes priority over hold. `ready_o` is 0 while stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_i | input | 1 | Start the wavefront when stopped |
| hold_i | input | 1 | Stall request (level) |
| retire_i | input | 1 | Wavefront end, start draining |
| issue_i | input | 6 | Per-kind issue pulses |
| done_i | input | 6 | Per-kind completion pulses |
| wait_load_i | input | 1 | Load thresholds from a wait instruction |
| wait_clear_i | input | 1 | Set all thresholds to all ones |
| vm_thr_i | input | 6 | Vector-memory class threshold |
| wr_thr_i | input | 6 | Write class threshold |
| sh_thr_i | input | 6 | Shared class threshold |
| oldest_is_wait_i | input | 1 | Oldest buffered instruction is the wait instruction |
| ready_o | output | 1 | Wavefront may issue |
| status_o | output | 3 | Status code |
| err_o | output | 1 | Counter underflow or overflow seen on the previous cycle |

## Verification
A counter that drifts shows up at the ports only indirectly: a wrong count moves the cycle where `ready_o` rises in the waiting status, or the cycle where returning drains to stopped. It can also raise `err_o` one cycle early or late. A wrong class grouping shows up as a ready decision that depends on traffic it should ignore. The bench therefore compares status, ready and error on every cycle against its own model. With random thresholds near the live counts, each count error appears within a few cycles of the wavefront entering the waiting status.

// File: rtl/memwait_pkg.sv
// Shared constants and types for the wait-count issue gate.
// Assumes exactly six traffic kinds and three wait classes.
package memwait_pkg;

    localparam int NKIND  = 6;
    localparam int NCLASS = 3;

    localparam int K_GRD = 0;
    localparam int K_GWR = 1;
    localparam int K_LRD = 2;
    localparam int K_LWR = 3;
    localparam int K_SRD = 4;
    localparam int K_SWR = 5;

    localparam int C_VM = 0;
    localparam int C_WR = 1;
    localparam int C_SH = 2;

    typedef enum logic [2:0] {
        WS_STOPPED   = 3'd0,
        WS_RETURNING = 3'd1,
        WS_RUNNING   = 3'd2,
        WS_STALLED   = 3'd3,
        WS_WAITING   = 3'd4
    } wstat_e;

    // Which traffic kinds contribute to a wait class (R4).
    function automatic logic [NKIND-1:0] class_mask(input int c);
        logic [NKIND-1:0] m;
        m = '0;
        case (c)
            C_VM:    begin m[K_GRD] = 1'b1; m[K_GWR] = 1'b1; end
            C_WR:    m[K_GWR] = 1'b1;
            default: begin
                m[K_LRD] = 1'b1; m[K_LWR] = 1'b1;
                m[K_SRD] = 1'b1; m[K_SWR] = 1'b1;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mw_kind_counter.sv
// One saturating outstanding-operation counter.
// Issue adds one and completion subtracts one, and both together cancel.
// A step past either end is refused and flagged on fault_o (combinational).
module mw_kind_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] cnt_o,
    output logic         fault_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic up;
    logic dn;

    // Decode the net direction and detect out-of-range steps.
    always_comb begin
        up      = inc_i & ~dec_i;
        dn      = dec_i & ~inc_i;
        fault_o = (up && cnt_o == MAXV) || (dn && cnt_o == '0);
    end

    // Hold the count, and never wrap it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (up && cnt_o != MAXV)
            cnt_o <= cnt_o + 1'b1;
        else if (dn && cnt_o != '0)
            cnt_o <= cnt_o - 1'b1;
    end
endmodule

// File: rtl/mw_class_eval.sv
// Adds the per-kind counts into class counts and compares each with its threshold.
// A threshold of all ones always counts as met. idle_o reports all counts zero.
module mw_class_eval #(
    parameter int W  = 6,
    parameter int NK = memwait_pkg::NKIND,
    parameter int NC = memwait_pkg::NCLASS
) (
    input  logic [NK-1:0][W-1:0] cnt_i,
    input  logic [NC-1:0][W-1:0] thr_i,
    output logic [NC-1:0]        met_o,
    output logic                 all_met_o,
    output logic                 idle_o
);
    localparam int SW = W + $clog2(NK);
    localparam logic [W-1:0] NOWAIT = '1;

    for (genvar c = 0; c < NC; c++) begin : g_class
        localparam logic [NK-1:0] MASK = memwait_pkg::class_mask(c);
        logic [SW-1:0] sum;

        // Add up the counts of the kinds in this class and compare the total.
        always_comb begin
            sum = '0;
            for (int k = 0; k < NK; k++)
                if (MASK[k]) sum = sum + SW'(cnt_i[k]);
            met_o[c] = (thr_i[c] == NOWAIT) || (sum <= SW'(thr_i[c]));
        end
    end

    // Reduce the class results and detect that nothing is outstanding.
    always_comb begin
        all_met_o = &met_o;
        idle_o    = 1'b1;
        for (int k = 0; k < NK; k++)
            if (cnt_i[k] != '0) idle_o = 1'b0;
    end
endmodule

// File: rtl/mw_status_fsm.sv
// Wavefront status machine and issue-ready decision.
// Assumes load_ok already excludes a load that a clear cancels.
module mw_status_fsm
    import memwait_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch_i,
    input  logic   hold_i,
    input  logic   retire_i,
    input  logic   load_ok_i,
    input  logic   all_met_i,
    input  logic   idle_i,
    input  logic   oldest_i,
    output wstat_e state_o,
    output logic   ready_o
);
    wstat_e nxt;

    // Next-status selection. In running: retire, then load, then hold.
    always_comb begin
        nxt = state_o;
        case (state_o)
            WS_STOPPED:   if (launch_i) nxt = WS_RUNNING;
            WS_RUNNING: begin
                if (retire_i)       nxt = WS_RETURNING;
                else if (load_ok_i) nxt = WS_WAITING;
                else if (hold_i)    nxt = WS_STALLED;
            end
            WS_STALLED:   if (!hold_i) nxt = WS_RUNNING;
            WS_WAITING:   if (!load_ok_i && all_met_i) nxt = WS_RUNNING;
            WS_RETURNING: if (idle_i) nxt = WS_STOPPED;
            default:      nxt = WS_STOPPED;
        endcase
    end

    // Status register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_o <= WS_STOPPED;
        else        state_o <= nxt;
    end

    // Issue permission for the current status.
    always_comb begin
        ready_o = (state_o == WS_RUNNING) ||
                  (state_o == WS_WAITING && oldest_i && all_met_i);
    end
endmodule

// File: rtl/memwait_gate.sv
// Top of the wait-count issue gate: per-kind counters, threshold store,
// class evaluation and status machine. Inputs are assumed synchronous to clk.
module memwait_gate
    import memwait_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          hold_i,
    input  logic          retire_i,
    input  logic [5:0]    issue_i,
    input  logic [5:0]    done_i,
    input  logic          wait_load_i,
    input  logic          wait_clear_i,
    input  logic [CW-1:0] vm_thr_i,
    input  logic [CW-1:0] wr_thr_i,
    input  logic [CW-1:0] sh_thr_i,
    input  logic          oldest_is_wait_i,
    output logic          ready_o,
    output logic [2:0]    status_o,
    output logic          err_o
);
    logic [NKIND-1:0][CW-1:0]  cnt;
    logic [NKIND-1:0]          fault;
    logic [NCLASS-1:0][CW-1:0] thr_q;
    logic [NCLASS-1:0]         met;
    logic                      all_met;
    logic                      idle;
    logic                      load_ok;
    wstat_e                    state;

    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        mw_kind_counter #(.W(CW)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc_i   (issue_i[k]),
            .dec_i   (done_i[k]),
            .cnt_o   (cnt[k]),
            .fault_o (fault[k])
        );
    end

    mw_class_eval #(.W(CW), .NK(NKIND), .NC(NCLASS)) u_eval (
        .cnt_i     (cnt),
        .thr_i     (thr_q),
        .met_o     (met),
        .all_met_o (all_met),
        .idle_o    (idle)
    );

    // A clear cancels a load given in the same cycle.
    always_comb load_ok = wait_load_i & ~wait_clear_i;

    // Threshold store: clear first, otherwise a load while running or waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || wait_clear_i) begin
            thr_q <= '1;
        end else if (load_ok && (state == WS_RUNNING || state == WS_WAITING)) begin
            thr_q[C_VM] <= vm_thr_i;
            thr_q[C_WR] <= wr_thr_i;
            thr_q[C_SH] <= sh_thr_i;
        end
    end

    // One-cycle error flag from any refused counter step.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= |fault;
    end

    mw_status_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch_i),
        .hold_i    (hold_i),
        .retire_i  (retire_i),
        .load_ok_i (load_ok),
        .all_met_i (all_met),
        .idle_i    (idle),
        .oldest_i  (oldest_is_wait_i),
        .state_o   (state),
        .ready_o   (ready_o)
    );

    // Drive the status port from the state register.
    always_comb status_o = state;
endmodule

// File: rtl/memwait_gate_chk.sv
// Temporal checks on the wait-count issue gate, attached by bind.
module memwait_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       launch_i,
    input logic       retire_i,
    input logic       wait_load_i,
    input logic       wait_clear_i,
    input logic       oldest_is_wait_i,
    input logic [5:0] issue_i,
    input logic [5:0] done_i,
    input logic       ready_o,
    input logic [2:0] status_o,
    input logic       err_o,
    input logic       all_met,
    input logic       idle
);
    localparam logic [2:0] S_STOP = 3'd0;
    localparam logic [2:0] S_RET  = 3'd1;
    localparam logic [2:0] S_RUN  = 3'd2;
    localparam logic [2:0] S_STL  = 3'd3;
    localparam logic [2:0] S_WAIT = 3'd4;

    assert_legal_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_o <= S_WAIT);

    assert_stopped_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_STOP && !launch_i) |=> status_o == S_STOP);

    assert_wait_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_RUN && wait_load_i && !wait_clear_i && !retire_i) |=> status_o == S_WAIT);

    assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_WAIT && ready_o) |-> (oldest_is_wait_i && all_met));

    assert_wait_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_WAIT && all_met && !(wait_load_i && !wait_clear_i)) |=> status_o == S_RUN);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n) && err_o) |-> $past(|(issue_i | done_i)));

    assert_drain_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_RET && !idle) |=> status_o == S_RET);

    assert_no_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == S_STL || status_o == S_RET || status_o == S_STOP) |-> !ready_o);
endmodule

bind memwait_gate memwait_gate_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .launch_i         (launch_i),
    .retire_i         (retire_i),
    .wait_load_i      (wait_load_i),
    .wait_clear_i     (wait_clear_i),
    .oldest_is_wait_i (oldest_is_wait_i),
    .issue_i          (issue_i),
    .done_i           (done_i),
    .ready_o          (ready_o),
    .status_o         (status_o),
    .err_o            (err_o),
    .all_met          (all_met),
    .idle             (idle)
);

// File: tb/sim_memwait_gate.sv
`timescale 1ns/1ps
module sim_memwait_gate;
    localparam int ST_STOP = 0, ST_RET = 1, ST_RUN = 2, ST_STL = 3, ST_WAIT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       launch_i = 0, hold_i = 0, retire_i = 0;
    logic [5:0] issue_i = '0, done_i = '0;
    logic       wait_load_i = 0, wait_clear_i = 0;
    logic [5:0] vm_thr_i = '0, wr_thr_i = '0, sh_thr_i = '0;
    logic       oldest_is_wait_i = 0;
    logic       ready_o;
    logic [2:0] status_o;
    logic       err_o;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model state.
    int mc[6];
    int mthr[3];
    int mst;
    bit merr;

    always #5 clk = ~clk;

    memwait_gate u0 (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .hold_i(hold_i),
        .retire_i(retire_i), .issue_i(issue_i), .done_i(done_i),
        .wait_load_i(wait_load_i), .wait_clear_i(wait_clear_i),
        .vm_thr_i(vm_thr_i), .wr_thr_i(wr_thr_i), .sh_thr_i(sh_thr_i),
        .oldest_is_wait_i(oldest_is_wait_i), .ready_o(ready_o),
        .status_o(status_o), .err_o(err_o)
    );

    function automatic bit class_ok(int sum, int thr);
        return (thr == 63) || (sum <= thr);
    endfunction

    function automatic bit m_met();
        return class_ok(mc[0] + mc[1], mthr[0]) &&
               class_ok(mc[1], mthr[1]) &&
               class_ok(mc[2] + mc[3] + mc[4] + mc[5], mthr[2]);
    endfunction

    function automatic bit m_idle();
        for (int k = 0; k < 6; k++) if (mc[k] != 0) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare outputs for the current inputs, advance the model over the
    // coming edge, then wait for the next negedge and drop the pulses.
    task automatic step(string tag);
        bit rdy, met, idle, lok, errn;
        int nst;
        #1;
        met  = m_met();
        idle = m_idle();
        rdy  = (mst == ST_RUN) || (mst == ST_WAIT && oldest_is_wait_i && met);
        chk(tag, "status", int'(status_o), mst);
        chk(tag, "ready", int'(ready_o), int'(rdy));
        chk(tag, "err", int'(err_o), int'(merr));
        lok = wait_load_i && !wait_clear_i;
        nst = mst;
        case (mst)
            ST_STOP: if (launch_i) nst = ST_RUN;
            ST_RUN:  if (retire_i) nst = ST_RET;
                     else if (lok) nst = ST_WAIT;
                     else if (hold_i) nst = ST_STL;
            ST_STL:  if (!hold_i) nst = ST_RUN;
            ST_WAIT: if (!lok && met) nst = ST_RUN;
            ST_RET:  if (idle) nst = ST_STOP;
            default: nst = ST_STOP;
        endcase
        if (wait_clear_i) begin
            mthr[0] = 63; mthr[1] = 63; mthr[2] = 63;
        end else if (lok && (mst == ST_RUN || mst == ST_WAIT)) begin
            mthr[0] = vm_thr_i; mthr[1] = wr_thr_i; mthr[2] = sh_thr_i;
        end
        errn = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (issue_i[k] && !done_i[k]) begin
                if (mc[k] == 63) errn = 1'b1; else mc[k]++;
            end else if (done_i[k] && !issue_i[k]) begin
                if (mc[k] == 0) errn = 1'b1; else mc[k]--;
            end
        end
        merr = errn;
        mst  = nst;
        @(negedge clk);
        launch_i = 0; retire_i = 0; issue_i = '0; done_i = '0;
        wait_load_i = 0; wait_clear_i = 0;
    endtask

    task automatic load_thr(int v, int w, int s, string tag);
        vm_thr_i = 6'(v); wr_thr_i = 6'(w); sh_thr_i = 6'(s);
        wait_load_i = 1;
        step(tag);
    endtask

    initial begin
        #1_500_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 6; k++) mc[k] = 0;
        mthr[0] = 63; mthr[1] = 63; mthr[2] = 63;
        mst = ST_STOP; merr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, then stopped holds without launch
        step("R1");
        step("R2");
        // R2: launch to running, ready while running
        launch_i = 1; step("R2");
        step("R2");
        // R3: counting, paired issue and completion cancel
        issue_i = 6'b000001; step("R3");
        issue_i = 6'b000001; step("R3");
        issue_i = 6'b000001; step("R3");
        issue_i = 6'b000001; done_i = 6'b000001; step("R3");
        // R5 then R6: three global reads against a limit of two
        oldest_is_wait_i = 1;
        load_thr(2, 63, 63, "R5");
        step("R6");
        oldest_is_wait_i = 0; step("R6");
        oldest_is_wait_i = 1;
        done_i = 6'b000001; step("R6");
        // R7: the limit is now met, so ready, then back to running
        step("R7");
        step("R7");
        done_i = 6'b000001; step("R3");
        done_i = 6'b000001; step("R3");
        // R4: local and scalar traffic does not count for the vector-memory class
        issue_i = 6'b111100; step("R4");
        load_thr(0, 0, 63, "R4");
        step("R4");
        load_thr(63, 63, 3, "R4");
        step("R4");
        done_i = 6'b000100; step("R4");
        step("R4");
        // R4: a global write counts in the write class
        issue_i = 6'b000010; step("R4");
        load_thr(63, 0, 63, "R4");
        step("R4");
        // R8: a clear wins over a load and releases the wait
        wait_clear_i = 1; wait_load_i = 1; vm_thr_i = 0; wr_thr_i = 0; sh_thr_i = 0;
        step("R8");
        step("R8");
        load_thr(63, 63, 63, "R8");
        step("R8");
        // R9: completion at zero and issue at the top both flag and hold
        done_i = 6'b000001; step("R9");
        step("R9");
        for (int i = 0; i < 63; i++) begin issue_i = 6'b100000; step("R3"); end
        issue_i = 6'b100000; step("R9");
        step("R9");
        for (int i = 0; i < 60; i++) begin done_i = 6'b100000; step("R3"); end
        // R11: hold stalls, priority of load over hold
        hold_i = 1; step("R11");
        step("R11");
        hold_i = 0; step("R11");
        hold_i = 1; load_thr(63, 63, 63, "R11");
        step("R11");
        hold_i = 0; step("R11");
        // R10: retire, then drain to stopped
        retire_i = 1; wait_load_i = 1; step("R10");
        step("R10");
        for (int k = 0; k < 6; k++)
            while (mc[k] > 0) begin done_i = 6'(1 << k); step("R10"); end
        step("R10");
        step("R10");
        // Random phase over all requirements
        void'($urandom(32'd1234));
        for (int i = 0; i < 6000; i++) begin
            for (int k = 0; k < 6; k++) begin
                issue_i[k] = ($urandom_range(0, 99) < 22);
                done_i[k]  = ($urandom_range(0, 99) < 22);
            end
            launch_i         = ($urandom_range(0, 99) < 30);
            retire_i         = ($urandom_range(0, 99) < 2);
            hold_i           = ($urandom_range(0, 99) < 6);
            wait_load_i      = ($urandom_range(0, 99) < 8);
            wait_clear_i     = ($urandom_range(0, 99) < 2);
            oldest_is_wait_i = ($urandom_range(0, 99) < 75);
            vm_thr_i = ($urandom_range(0, 9) == 0) ? 6'd63 : 6'($urandom_range(0, 6));
            wr_thr_i = ($urandom_range(0, 9) == 0) ? 6'd63 : 6'($urandom_range(0, 3));
            sh_thr_i = ($urandom_range(0, 9) == 0) ? 6'd63 : 6'($urandom_range(0, 10));
            step("R3 R4 R6 R7 R9 random");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule